// File: doc/BRIEF.md
# Dual-Bank IRQ/FIQ Interrupt Controller

This block gathers forty level-sensitive interrupt sources into two 32-bit banks. Bank 0 holds sources 0 to 31. Bits 7:0 of bank 1 hold sources 32 to 39. The raw pending state of each source follows its input level, with no latching. A per-source enable bit decides whether that source can request service. A per-source route bit sends the source either to the fast request line (FIQ, route bit 1) or to the normal request line (IRQ, route bit 0). Both request lines are registered levels and cover both banks.

While the core reports itself halted, a wake output is raised when a pending source is enabled. A control bit can also let any pending source wake the core, enabled or not. A programmable table of forty priority slots drives a separate resolver. The resolver reports the highest-priority active IRQ source and FIQ source through a read-only register. Software reaches every register through a single-cycle, word-wide register port. Read data is registered.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset:
  - enables, routes and pending state are zero;
  - every priority slot reads 0;
  - the control register reads 1;
  - the resolver register reads 0x003F003F;
  - irq_o, fiq_o and wake_o are low.
- R2: Raw pending is sampled from src_lvl on every clock edge. Sources 0..31 read at offset 0x10, bits 31:0. Sources 32..39 read at offset 0xAC, bits 7:0.
- R3: The IRQ-pending view reads raw AND enable AND NOT route, at 0x00 for bank 0 and 0x9C for bank 1. The FIQ-pending view reads raw AND enable AND route, at 0x0C and 0xA8.
- R4: On the edge after the pending, enable and route registers, irq_o is driven high exactly when some source is pending, enabled and routed to IRQ. fiq_o is driven the same way for sources routed to FIQ.
- R5: Control register at 0x14:
  - writing bit 0 = 1 closes the idle path;
  - writing bit 0 = 0 opens it;
  - a read returns 1 when the path is closed, 0 when it is open, with bits 31:1 zero.
- R6: On the edge after the inputs, wake_o is driven high exactly when halted is high and some pending source is either enabled or passed by an open idle path.
- R7: There are forty priority slots. Slots 0..31 sit at 0x1C + 4*n. Slots 32..39 sit at 0xB0 + 4*(n-32). A write keeps only bit 31 (valid) and bits 5:0 (source number) and stores every other bit as zero.
- R8: The resolver register at 0x18 has this layout:
  - bit 31 is the IRQ-found flag and bits 21:16 the IRQ source number;
  - bit 15 is the FIQ-found flag and bits 5:0 the FIQ source number;
  - all other bits read zero;
  - a field with no winner reads flag 0 and number 0x3F.
  
  The winner is the source named by the lowest-numbered slot that is valid, names a source below 40, and whose source is pending, enabled and routed to that line.
- R9: Reads of undefined offsets return 0. Undefined offsets are any offset with bits 1:0 nonzero and any offset above 0xCC. Writes to undefined offsets, and writes to the read-only views (0x00, 0x0C, 0x10, 0x18, 0x9C, 0xA8, 0xAC), change no state.
- R10: In bank 1, bits 31:8 of the enable (0xA0), route (0xA4), raw, IRQ-pending and FIQ-pending registers always read 0.
- R11: Enables are read and written at 0x04 and 0xA0, routes at 0x08 and 0xA4. Read data appears one clock after the read strobe and holds while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 40 | Source input levels |
| halted | input | 1 | Core reports it is halted |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
The hardest state to reach is a resolver contest between competing sources. Here several slots name live sources on the same line, some slots are invalid or name numbers of 40 and above, and sources that share a line are routed differently. The bench reaches it by filling all forty slots with arithmetic patterns that mix valid, invalid and out-of-range entries. It then sweeps derived source, enable and route words over both banks and compares the resolver against a forward scan of the slot table. A second sweep writes all ones to every undefined and read-only offset, then reads back each stored register.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DEF_NSRC = 40;
    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int IDW      = 6;
    localparam int BANK_W   = 32;

    // fixed register offsets; the bank-1 views mirror bank 0
    localparam int OFS_IRQP0  = 'h00;
    localparam int OFS_EN0    = 'h04;
    localparam int OFS_ROUTE0 = 'h08;
    localparam int OFS_FIQP0  = 'h0C;
    localparam int OFS_RAW0   = 'h10;
    localparam int OFS_CTRL   = 'h14;
    localparam int OFS_HIGH   = 'h18;
    localparam int OFS_SLOT0  = 'h1C;
    localparam int OFS_IRQP1  = 'h9C;
    localparam int OFS_EN1    = 'hA0;
    localparam int OFS_ROUTE1 = 'hA4;
    localparam int OFS_FIQP1  = 'hA8;
    localparam int OFS_RAW1   = 'hAC;
    localparam int OFS_SLOT32 = 'hB0;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IRQP0, SEL_EN0, SEL_ROUTE0, SEL_FIQP0, SEL_RAW0,
        SEL_CTRL, SEL_HIGH, SEL_SLOT,
        SEL_IRQP1, SEL_EN1, SEL_ROUTE1, SEL_FIQP1, SEL_RAW1
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic [IDW-1:0]  slot;
    } dec_t;

    typedef struct packed {
        logic            vld;
        logic [IDW-1:0]  src;
    } slot_t;

    typedef struct packed {
        logic            irq_hit;
        logic [8:0]      pad_hi;
        logic [IDW-1:0]  irq_src;
        logic            fiq_hit;
        logic [8:0]      pad_lo;
        logic [IDW-1:0]  fiq_src;
    } high_t;

    localparam logic [IDW-1:0] NO_SRC = '1;

    function automatic dec_t decode(input logic [AW-1:0] addr, input int nsrc);
        dec_t d;
        int   a;
        a      = int'(addr);
        d.sel  = SEL_NONE;
        d.slot = '0;
        if (addr[1:0] == 2'b00) begin
            if (a == OFS_IRQP0)       d.sel = SEL_IRQP0;
            else if (a == OFS_EN0)    d.sel = SEL_EN0;
            else if (a == OFS_ROUTE0) d.sel = SEL_ROUTE0;
            else if (a == OFS_FIQP0)  d.sel = SEL_FIQP0;
            else if (a == OFS_RAW0)   d.sel = SEL_RAW0;
            else if (a == OFS_CTRL)   d.sel = SEL_CTRL;
            else if (a == OFS_HIGH)   d.sel = SEL_HIGH;
            else if (a == OFS_IRQP1)  d.sel = SEL_IRQP1;
            else if (a == OFS_EN1)    d.sel = SEL_EN1;
            else if (a == OFS_ROUTE1) d.sel = SEL_ROUTE1;
            else if (a == OFS_FIQP1)  d.sel = SEL_FIQP1;
            else if (a == OFS_RAW1)   d.sel = SEL_RAW1;
            else if (a >= OFS_SLOT0 && a < OFS_SLOT0 + 4 * BANK_W) begin
                d.sel  = SEL_SLOT;
                d.slot = IDW'((a - OFS_SLOT0) >> 2);
            end else if (a >= OFS_SLOT32 && a < OFS_SLOT32 + 4 * (nsrc - BANK_W)) begin
                d.sel  = SEL_SLOT;
                d.slot = IDW'(BANK_W + ((a - OFS_SLOT32) >> 2));
            end
        end
        return d;
    endfunction

    function automatic logic is_bank1_view(input reg_sel_e s);
        return (s == SEL_IRQP1) || (s == SEL_EN1) || (s == SEL_ROUTE1) ||
               (s == SEL_FIQP1) || (s == SEL_RAW1);
    endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NSRC = DEF_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            wr_en,
    input  dec_t            dec,
    input  logic [DW-1:0]   wdata,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] route_q,
    output logic            idle_open_q,
    output slot_t           slot_q [NSRC]
);
    localparam int B1W = NSRC - BANK_W;

    // raw pending tracks the pins with one register stage
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= src_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= '0;
            route_q     <= '0;
            idle_open_q <= 1'b0;
        end else if (wr_en) begin
            case (dec.sel)
                SEL_EN0:    en_q[BANK_W-1:0]       <= wdata[BANK_W-1:0];
                SEL_EN1:    en_q[NSRC-1:BANK_W]    <= wdata[B1W-1:0];
                SEL_ROUTE0: route_q[BANK_W-1:0]    <= wdata[BANK_W-1:0];
                SEL_ROUTE1: route_q[NSRC-1:BANK_W] <= wdata[B1W-1:0];
                SEL_CTRL:   idle_open_q            <= ~wdata[0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (wr_en && dec.sel == SEL_SLOT && dec.slot == IDW'(g)) begin
                slot_q[g].vld <= wdata[DW-1];
                slot_q[g].src <= wdata[IDW-1:0];
            end
        end
    end

endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
    import intc_pkg::*;
#(
    parameter int NSRC = DEF_NSRC
) (
    input  logic [NSRC-1:0] active,
    input  logic [NSRC-1:0] route,
    input  slot_t           slot [NSRC],
    output high_t           high
);
    localparam int SPAN = 1 << IDW;
    localparam logic [IDW-1:0] LIM = IDW'(NSRC);

    logic [SPAN-1:0] act_x;
    logic [SPAN-1:0] rte_x;

    assign act_x = {{(SPAN-NSRC){1'b0}}, active};
    assign rte_x = {{(SPAN-NSRC){1'b0}}, route};

    // scan from the weakest slot down so that lower slots overwrite
    always_comb begin
        high         = '0;
        high.irq_src = NO_SRC;
        high.fiq_src = NO_SRC;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (slot[i].vld && slot[i].src < LIM && act_x[slot[i].src]) begin
                if (rte_x[slot[i].src]) begin
                    high.fiq_hit = 1'b1;
                    high.fiq_src = slot[i].src;
                end else begin
                    high.irq_hit = 1'b1;
                    high.irq_src = slot[i].src;
                end
            end
        end
    end

endmodule

// File: rtl/intc_req.sv
module intc_req
    import intc_pkg::*;
#(
    parameter int NSRC = DEF_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] route,
    input  logic            idle_open,
    input  logic            halted,
    output logic            irq_o,
    output logic            fiq_o,
    output logic            wake_o
);
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] wake_src;

    assign live     = pend & en;
    assign wake_src = pend & (en | {NSRC{idle_open}});

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o  <= 1'b0;
            fiq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |(live & ~route);
            fiq_o  <= |(live & route);
            wake_o <= halted && (|wake_src);
        end
    end

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter int NSRC = DEF_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            halted,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_o,
    output logic            fiq_o,
    output logic            wake_o
);
    localparam int B1W = NSRC - BANK_W;

    dec_t            dec;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] route_q;
    logic            idle_open_q;
    slot_t           slot_q [NSRC];
    high_t           high;
    logic [NSRC-1:0] irq_view;
    logic [NSRC-1:0] fiq_view;
    slot_t           slot_pick;
    logic [DW-1:0]   rd_mux;

    assign dec = decode(reg_addr, NSRC);

    intc_regs #(.NSRC(NSRC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .src_lvl     (src_lvl),
        .wr_en       (reg_wr),
        .dec         (dec),
        .wdata       (reg_wdata),
        .pend_q      (pend_q),
        .en_q        (en_q),
        .route_q     (route_q),
        .idle_open_q (idle_open_q),
        .slot_q      (slot_q)
    );

    intc_resolver #(.NSRC(NSRC)) u_res (
        .active (pend_q & en_q),
        .route  (route_q),
        .slot   (slot_q),
        .high   (high)
    );

    intc_req #(.NSRC(NSRC)) u_req (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_q),
        .en        (en_q),
        .route     (route_q),
        .idle_open (idle_open_q),
        .halted    (halted),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .wake_o    (wake_o)
    );

    assign irq_view = pend_q & en_q & ~route_q;
    assign fiq_view = pend_q & en_q & route_q;

    always_comb begin
        slot_pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (dec.slot == IDW'(i)) slot_pick = slot_q[i];
        end
    end

    always_comb begin
        case (dec.sel)
            SEL_IRQP0:  rd_mux = irq_view[BANK_W-1:0];
            SEL_EN0:    rd_mux = en_q[BANK_W-1:0];
            SEL_ROUTE0: rd_mux = route_q[BANK_W-1:0];
            SEL_FIQP0:  rd_mux = fiq_view[BANK_W-1:0];
            SEL_RAW0:   rd_mux = pend_q[BANK_W-1:0];
            SEL_CTRL:   rd_mux = {{(DW-1){1'b0}}, ~idle_open_q};
            SEL_HIGH:   rd_mux = high;
            SEL_SLOT:   rd_mux = {slot_pick.vld, {(DW-1-IDW){1'b0}}, slot_pick.src};
            SEL_IRQP1:  rd_mux = {{(DW-B1W){1'b0}}, irq_view[NSRC-1:BANK_W]};
            SEL_EN1:    rd_mux = {{(DW-B1W){1'b0}}, en_q[NSRC-1:BANK_W]};
            SEL_ROUTE1: rd_mux = {{(DW-B1W){1'b0}}, route_q[NSRC-1:BANK_W]};
            SEL_FIQP1:  rd_mux = {{(DW-B1W){1'b0}}, fiq_view[NSRC-1:BANK_W]};
            SEL_RAW1:   rd_mux = {{(DW-B1W){1'b0}}, pend_q[NSRC-1:BANK_W]};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int NSRC = DEF_NSRC
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_rd,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_rdata,
    input logic            halted,
    input logic            irq_o,
    input logic            fiq_o,
    input logic            wake_o,
    input logic [NSRC-1:0] pend_q
);
    localparam int B1W = NSRC - BANK_W;

    dec_t d;
    assign d = decode(reg_addr, NSRC);

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && d.sel == SEL_NONE) |=> (reg_rdata == '0));

    p_bank1_upper_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && is_bank1_view(d.sel)) |=> (reg_rdata[DW-1:B1W] == '0));

    p_slot_fmt_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && d.sel == SEL_SLOT) |=> (reg_rdata[DW-2:IDW] == '0));

    p_ctrl_fmt_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && d.sel == SEL_CTRL) |=> (reg_rdata[DW-1:1] == '0));

    p_high_pad_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && d.sel == SEL_HIGH) |=> (reg_rdata[30:22] == '0 && reg_rdata[14:6] == '0));

    p_wake_halt_r6: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(halted));

    p_irq_pend_r4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|pend_q));

    p_fiq_pend_r4: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> $past(|pend_q));

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind dual_bank_intc intc_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .halted    (halted),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .wake_o    (wake_o),
    .pend_q    (pend_q)
);

// File: tb/sim_dual_bank_intc.sv
`timescale 1ns/1ps
module sim_dual_bank_intc;
    localparam int NSRC = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_lvl = '0;
    logic            halted = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_o, fiq_o, wake_o;

    int n_chk = 0;
    int n_err = 0;

    logic [NSRC-1:0] m_en = '0;
    logic [NSRC-1:0] m_route = '0;
    logic            m_open = 1'b0;
    logic [31:0]     m_slot [NSRC];

    always #10 clk = ~clk;

    dual_bank_intc u0 (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .halted(halted),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] slot_addr(input int n);
        return (n < 32) ? 8'(8'h1C + 4 * n) : 8'(8'hB0 + 4 * (n - 32));
    endfunction

    function automatic logic [31:0] exp_high(input logic [NSRC-1:0] src);
        logic irq_f = 1'b0, fiq_f = 1'b0;
        logic [5:0] ii = 6'h3F, fi = 6'h3F;
        for (int i = 0; i < NSRC; i++) begin
            int s = int'(m_slot[i][5:0]);
            if (m_slot[i][31] && s < NSRC && src[s] && m_en[s]) begin
                if (m_route[s]) begin
                    if (!fiq_f) begin fiq_f = 1'b1; fi = 6'(s); end
                end else begin
                    if (!irq_f) begin irq_f = 1'b1; ii = 6'(s); end
                end
            end
        end
        return {irq_f, 9'b0, ii, fiq_f, 9'b0, fi};
    endfunction

    task automatic set_en(input logic [NSRC-1:0] v);
        m_en = v;
        wr(8'h04, v[31:0]);
        wr(8'hA0, {24'hFFFFFF, v[39:32]});
    endtask

    task automatic set_route(input logic [NSRC-1:0] v);
        m_route = v;
        wr(8'h08, v[31:0]);
        wr(8'hA4, {24'hABCDEF, v[39:32]});
    endtask

    task automatic check_views(input string tag, input logic [NSRC-1:0] src);
        logic [31:0] d;
        logic [NSRC-1:0] iv, fv;
        iv = src & m_en & ~m_route;
        fv = src & m_en & m_route;
        rd(8'h00, d); chk({"R3 irq0 ", tag}, d, iv[31:0]);
        rd(8'h9C, d); chk({"R3 irq1 ", tag}, d, {24'h0, iv[39:32]});
        rd(8'h0C, d); chk({"R3 fiq0 ", tag}, d, fv[31:0]);
        rd(8'hA8, d); chk({"R3 fiq1 ", tag}, d, {24'h0, fv[39:32]});
        rd(8'h18, d); chk({"R8 high ", tag}, d, exp_high(src));
        chk({"R4 irq_o ", tag}, {31'h0, irq_o}, {31'h0, |iv});
        chk({"R4 fiq_o ", tag}, {31'h0, fiq_o}, {31'h0, |fv});
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NSRC; i++) m_slot[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
        chk("R1 fiq_o", {31'h0, fiq_o}, 32'h0);
        chk("R1 wake_o", {31'h0, wake_o}, 32'h0);
        rd(8'h14, d); chk("R1 ctrl", d, 32'h1);
        rd(8'h18, d); chk("R1 high", d, 32'h003F003F);
        rd(8'h04, d); chk("R1 en0", d, 32'h0);
        rd(8'hA4, d); chk("R1 route1", d, 32'h0);
        rd(8'h10, d); chk("R1 raw0", d, 32'h0);
        for (int n = 0; n < NSRC; n++) begin
            rd(slot_addr(n), d); chk("R1 slot", d, 32'h0);
        end

        // R2 walking one over every source
        for (int i = 0; i < NSRC; i++) begin
            logic [NSRC-1:0] s;
            s = '0; s[i] = 1'b1;
            @(negedge clk); src_lvl = s;
            @(negedge clk);
            rd(8'h10, d); chk("R2 raw0", d, s[31:0]);
            rd(8'hAC, d); chk("R2 raw1 R10", d, {24'h0, s[39:32]});
        end

        // R11 R10 enable/route read-back with upper bank-1 junk
        set_en({8'hA5, 32'h1234_5678});
        set_route({8'h3C, 32'h0F0F_00FF});
        rd(8'h04, d); chk("R11 en0", d, 32'h1234_5678);
        rd(8'hA0, d); chk("R11 R10 en1", d, 32'h0000_00A5);
        rd(8'h08, d); chk("R11 route0", d, 32'h0F0F_00FF);
        rd(8'hA4, d); chk("R11 R10 route1", d, 32'h0000_003C);

        // R7 slot write masking
        for (int n = 0; n < NSRC; n++) begin
            logic [31:0] v;
            v = 32'h7FFF_FFC0 ^ (32'(n) * 32'h0101_0107) ^ ((n % 3 != 0) ? 32'h8000_0000 : 32'h0);
            wr(slot_addr(n), v);
            m_slot[n] = v & 32'h8000_003F;
            rd(slot_addr(n), d); chk("R7 slot", d, m_slot[n]);
        end

        // R3 R4 R8 sweep of source/enable/route words
        for (int t = 0; t < 24; t++) begin
            logic [NSRC-1:0] s, e, r;
            s = {8'(t * 37 + 5), 32'(t) * 32'h9E37_79B9};
            e = {8'(t * 91 + 0), 32'(t + 3) * 32'h6C07_8965} | ((t % 4 == 0) ? '1 : '0);
            r = {8'(t * 13), 32'(t) * 32'h2545_F491};
            if (t == 0) s = '0;
            set_en(e);
            set_route(r);
            if (t % 5 == 1) begin
                for (int n = 0; n < 8; n++) begin
                    int k = (t + n * 5) % NSRC;
                    m_slot[k] = {1'b1, 25'h0, 6'((t * 7 + n * 11) % 44)};
                    wr(slot_addr(k), m_slot[k]);
                end
            end
            @(negedge clk); src_lvl = s;
            settle();
            check_views("sweep", s);
        end

        // R8 directed: slot 0 wins over slot 1 for both lines
        for (int n = 0; n < NSRC; n++) begin m_slot[n] = '0; wr(slot_addr(n), 32'h0); end
        set_en('1);
        set_route({1'b1, 1'b0, 38'h0} | 40'h1);
        m_slot[0] = {1'b1, 25'h0, 6'd39}; wr(slot_addr(0), m_slot[0]);
        m_slot[1] = {1'b1, 25'h0, 6'd0};  wr(slot_addr(1), m_slot[1]);
        m_slot[2] = {1'b1, 25'h0, 6'd38}; wr(slot_addr(2), m_slot[2]);
        m_slot[3] = {1'b1, 25'h0, 6'd5};  wr(slot_addr(3), m_slot[3]);
        m_slot[4] = {1'b1, 25'h0, 6'd45}; wr(slot_addr(4), m_slot[4]);
        @(negedge clk); src_lvl = '1;
        settle();
        rd(8'h18, d); chk("R8 directed both", d, {1'b1, 9'h0, 6'd38, 1'b1, 9'h0, 6'd39});
        m_slot[0] = 32'h0000_0027; wr(slot_addr(0), m_slot[0]);
        rd(8'h18, d); chk("R8 invalid slot skipped", d, {1'b1, 9'h0, 6'd38, 1'b1, 9'h0, 6'd0});

        // R5 R6 wake and control register
        for (int c = 0; c < 8; c++) begin
            logic h, op;
            logic [NSRC-1:0] s, e;
            h  = c[0];
            op = c[1];
            s  = 40'h80_0000_0100;
            e  = c[2] ? 40'h00_0000_0100 : 40'h0;
            set_en(e);
            wr(8'h14, {31'h7FFF_FFFF, ~op});
            m_open = op;
            rd(8'h14, d); chk("R5 ctrl read", d, {31'h0, ~op});
            @(negedge clk); src_lvl = s; halted = h;
            settle();
            chk("R6 wake", {31'h0, wake_o}, {31'h0, h && (|(s & (m_en | {NSRC{m_open}})))});
        end
        halted = 1'b0;

        // R9 undefined reads, ignored writes
        set_en({8'h5A, 32'hCAFE_F00D});
        set_route({8'hC3, 32'h1357_9BDF});
        for (int a = 0; a < 256; a++) begin
            if (a[1:0] != 2'b00 || a > 'hCC) begin
                rd(8'(a), d); chk("R9 undef read", d, 32'h0);
                wr(8'(a), 32'hFFFF_FFFF);
            end
        end
        wr(8'h00, '1); wr(8'h0C, '1); wr(8'h10, '1); wr(8'h18, '1);
        wr(8'h9C, '1); wr(8'hA8, '1); wr(8'hAC, '1);
        rd(8'h04, d); chk("R9 en0 kept", d, 32'hCAFE_F00D);
        rd(8'hA0, d); chk("R9 en1 kept", d, 32'h0000_005A);
        rd(8'h08, d); chk("R9 route0 kept", d, 32'h1357_9BDF);
        rd(8'hA4, d); chk("R9 route1 kept", d, 32'h0000_00C3);
        rd(8'h14, d); chk("R9 ctrl kept", d, {31'h0, ~m_open});
        for (int n = 0; n < NSRC; n++) begin
            rd(slot_addr(n), d); chk("R9 slot kept", d, m_slot[n]);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule